// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control core of a single DMA channel. Software programs a source address, a destination address, a per-trigger word count, a total word count, a fill word and a control word through a small indexed register port. The channel then requests the bus and moves 32-bit words, one per granted cycle. A word is read from the source and written to the destination. In fill mode, no read takes place and the fill word is written instead. After every word, each address is stepped by +4, -4 or 0 according to its own update field.

Three run modes decide how the counts are used. Immediate mode moves one per-trigger batch as soon as the channel is enabled, then switches the channel off. Repeating mode moves one batch for every trigger and keeps the channel on. The default mode also moves one batch per trigger, but it switches the channel off once the programmed total has been moved, even if that happens partway through a batch.

Arbitration between channels, selection of the trigger source and pacing between batches are handled outside the block. They reach the channel as the grant input, the single trigger input and the pacing enable input.

Top module: `dma_chan_seq`

## Requirements
- R1: Writing register index 0 (source) or 1 (destination) loads both the programmed and the working address, with the two low bits forced to zero. Reading the same index returns the working address. The total count is at index 2, the per-trigger count at index 3, the fill word at index 4 and control at index 5.
- R2: Control bits [11:10] select the destination step applied after each word moved: 0 adds 4, 1 subtracts 4, 2 leaves the address unchanged.
- R3: Control bits [14:13] select the source step: 0 adds 4, 1 subtracts 4, 2 leaves the address unchanged. The value 3 means no read strobe is issued and the fill word is written as data.
- R4: Control bit 12 (destination) and bit 15 (source) reload the working address from the programmed address at the end of every per-trigger batch.
- R5: With control bit 28 (immediate) set, enabling the channel through control bit 31 starts a batch of the per-trigger count without any trigger. When the batch is done, bit 31 reads back 0. The total count and bit 29 have no effect in this mode.
- R6: With bit 29 (repeat) set and bit 28 clear, every trigger moves one per-trigger batch and bit 31 stays set.
- R7: With bits 28 and 29 both clear, each trigger moves one per-trigger batch. The channel clears bit 31 and stops in the cycle the total count is used up, even if a batch is still unfinished.
- R8: A trigger that arrives during a batch is held as a single pending event, and a new batch starts right after the current one. Any further triggers in the same batch are merged into that one event.
- R9: A word moves only in a cycle where bus request, grant and the pacing enable are all high. The bus request stays high for the whole batch.
- R10: With control bit 30 set, irq pulses for one cycle after the final word of the channel's work. In repeat mode it also pulses after the final word of every batch.
- R11: Writing control with bit 31 clear stops the channel on the next clock edge and drops any pending trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| trig | input | 1 | Start event, one per cycle high |
| pace_ok | input | 1 | External pacing enable |
| bus_req | output | 1 | Bus request, high during a batch |
| bus_gnt | input | 1 | Bus grant |
| rd_en | output | 1 | Source read strobe |
| rd_addr | output | 32 | Source word address |
| rd_data | input | 32 | Read data, valid in the strobe cycle |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | 32 | Destination word address |
| wr_data | output | 32 | Write data |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The read and write strobes, their addresses and the write data follow grant and pacing in the same cycle. The bus request rises one clock edge after the enabling write or the trigger, and irq is high in the cycle after the last word. A behavioural model in the bench updates on each rising edge from the inputs that were stable before that edge. The bench drives inputs just after the rising edge and compares every output with the model at the falling edge, so each result is checked in the exact cycle it is due. Directed readbacks and word and interrupt tallies cover the enable flag, the reloads and the merging of triggers.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int RUN_CNT_W = 24;
    localparam int TOT_CNT_W = 28;
    localparam int REG_IDX_W = 3;

    typedef enum logic [1:0] {
        AS_INC  = 2'd0,
        AS_DEC  = 2'd1,
        AS_FIX  = 2'd2,
        AS_NONE = 2'd3
    } addr_step_e;

    typedef enum logic [REG_IDX_W-1:0] {
        RI_SRC   = 3'd0,
        RI_DST   = 3'd1,
        RI_TOTAL = 3'd2,
        RI_RUN   = 3'd3,
        RI_FILL  = 3'd4,
        RI_CTRL  = 3'd5
    } reg_idx_e;

    // control word layout: field positions are decoded by software
    typedef struct packed {
        logic       en;        // 31
        logic       irq_en;    // 30
        logic       rep;       // 29
        logic       imm;       // 28
        logic [3:0] rsv_hi;    // 27:24
        logic [7:0] rsv_mid;   // 23:16
        logic       src_rld;   // 15
        addr_step_e src_mode;  // 14:13
        logic       dst_rld;   // 12
        addr_step_e dst_mode;  // 11:10
        logic [9:0] rsv_lo;    // 9:0
    } ctrl_t;

    function automatic logic is_fill(input addr_step_e m);
        return m == AS_NONE;
    endfunction
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
    import dma_seq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_en,
    input  addr_step_e    mode,
    input  logic          reload,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] WORD_BYTES = AW'(4);

    logic [AW-1:0] prog_q;
    logic [AW-1:0] work_q;
    logic [AW-1:0] delta;

    always_comb begin
        unique case (mode)
            AS_INC:  delta = WORD_BYTES;
            AS_DEC:  delta = -WORD_BYTES;
            default: delta = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q <= '0;
            work_q <= '0;
        end else if (load) begin
            prog_q <= {load_val[AW-1:2], 2'b00};
            work_q <= {load_val[AW-1:2], 2'b00};
        end else if (reload) begin
            work_q <= prog_q;
        end else if (step_en) begin
            work_q <= work_q + delta;
        end
    end

    assign addr = work_q;
endmodule

// File: rtl/dma_word_count.sv
module dma_word_count #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec && count != '0) begin
            count <= count - W'(1);
        end
    end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W,
    parameter int RUN_W = RUN_CNT_W,
    parameter int TOT_W = TOT_CNT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [REG_IDX_W-1:0] reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    input  logic                 trig,
    input  logic                 pace_ok,
    output logic                 bus_req,
    input  logic                 bus_gnt,
    output logic                 rd_en,
    output logic [AW-1:0]        rd_addr,
    input  logic [DW-1:0]        rd_data,
    output logic                 wr_en,
    output logic [AW-1:0]        wr_addr,
    output logic [DW-1:0]        wr_data,
    output logic                 irq
);
    ctrl_t             ctrl_q;
    ctrl_t             ctrl_new;
    logic [DW-1:0]     fill_q;
    logic [RUN_W-1:0]  per_q;
    logic [TOT_W-1:0]  tot_q;
    logic [RUN_W-1:0]  run_left;
    logic [TOT_W-1:0]  tot_left;
    logic              en_q, busy_q, pend_q, irq_q;
    logic              en_d, busy_d, pend_d;
    logic              wr_ctrl, arm, stop;
    logic              one_shot, mv, last, fin, trig_acc, run_ld;
    logic              irq_evt;

    assign ctrl_new = ctrl_t'(reg_wdata[31:0]);
    assign wr_ctrl  = reg_wr && (reg_addr == RI_CTRL);
    assign arm      = wr_ctrl && ctrl_new.en && !en_q;
    assign stop     = wr_ctrl && !ctrl_new.en;
    assign one_shot = !ctrl_q.imm && !ctrl_q.rep;

    assign mv       = busy_q && bus_gnt && pace_ok;
    assign last     = mv && ((run_left == RUN_W'(1)) ||
                             (one_shot && tot_left == TOT_W'(1)));
    assign fin      = last && (ctrl_q.imm || (one_shot && tot_left == TOT_W'(1)));
    assign trig_acc = trig && en_q && !ctrl_q.imm;
    assign irq_evt  = last && (fin || ctrl_q.rep) && ctrl_q.irq_en;

    // channel state: register writes take precedence over transfer events
    always_comb begin
        en_d   = en_q;
        busy_d = busy_q;
        pend_d = pend_q;
        run_ld = 1'b0;
        if (stop) begin
            en_d   = 1'b0;
            busy_d = 1'b0;
            pend_d = 1'b0;
        end else if (arm) begin
            en_d   = 1'b1;
            busy_d = ctrl_new.imm;
            pend_d = 1'b0;
            run_ld = ctrl_new.imm;
        end else if (fin) begin
            en_d   = 1'b0;
            busy_d = 1'b0;
            pend_d = 1'b0;
        end else if (last) begin
            busy_d = pend_q || trig_acc;
            pend_d = 1'b0;
            run_ld = pend_q || trig_acc;
        end else if (trig_acc) begin
            if (busy_q) begin
                pend_d = 1'b1;
            end else begin
                busy_d = 1'b1;
                run_ld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            fill_q <= '0;
            per_q  <= '0;
            tot_q  <= '0;
            en_q   <= 1'b0;
            busy_q <= 1'b0;
            pend_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            en_q   <= en_d;
            busy_q <= busy_d;
            pend_q <= pend_d;
            irq_q  <= irq_evt;
            if (wr_ctrl) ctrl_q <= ctrl_new;
            if (reg_wr && reg_addr == RI_FILL)  fill_q <= reg_wdata;
            if (reg_wr && reg_addr == RI_RUN)   per_q  <= reg_wdata[RUN_W-1:0];
            if (reg_wr && reg_addr == RI_TOTAL) tot_q  <= reg_wdata[TOT_W-1:0];
        end
    end

    dma_word_count #(.W(RUN_W)) u_run_cnt (
        .clk(clk), .rst(rst), .load(run_ld), .load_val(per_q),
        .dec(mv), .count(run_left)
    );

    dma_word_count #(.W(TOT_W)) u_tot_cnt (
        .clk(clk), .rst(rst), .load(arm), .load_val(tot_q),
        .dec(mv), .count(tot_left)
    );

    dma_addr_unit #(.AW(AW)) u_src (
        .clk(clk), .rst(rst),
        .load(reg_wr && reg_addr == RI_SRC), .load_val(reg_wdata[AW-1:0]),
        .step_en(mv), .mode(ctrl_q.src_mode),
        .reload(last && ctrl_q.src_rld), .addr(rd_addr)
    );

    dma_addr_unit #(.AW(AW)) u_dst (
        .clk(clk), .rst(rst),
        .load(reg_wr && reg_addr == RI_DST), .load_val(reg_wdata[AW-1:0]),
        .step_en(mv), .mode(ctrl_q.dst_mode),
        .reload(last && ctrl_q.dst_rld), .addr(wr_addr)
    );

    assign bus_req = busy_q;
    assign wr_en   = mv;
    assign rd_en   = mv && !is_fill(ctrl_q.src_mode);
    assign wr_data = is_fill(ctrl_q.src_mode) ? fill_q : rd_data;
    assign irq     = irq_q;

    always_comb begin
        unique case (reg_addr)
            RI_SRC:   reg_rdata = DW'(rd_addr);
            RI_DST:   reg_rdata = DW'(wr_addr);
            RI_TOTAL: reg_rdata = DW'(tot_left);
            RI_RUN:   reg_rdata = DW'(per_q);
            RI_FILL:  reg_rdata = fill_q;
            RI_CTRL:  reg_rdata = DW'({en_q, ctrl_q[30:0]});
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_req,
    input logic        bus_gnt,
    input logic        pace_ok,
    input logic        wr_en,
    input logic        rd_en,
    input logic [1:0]  wr_addr_lo,
    input logic        irq,
    input logic        en_q,
    input logic        reg_wr,
    input logic [1:0]  src_mode_bits
);
    p_move_gated_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (bus_req && bus_gnt && pace_ok));

    p_fill_no_read_r3: assert property (@(posedge clk) disable iff (rst)
        (src_mode_bits == 2'b11) |-> !rd_en);

    p_req_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> en_q);

    p_irq_after_word_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(wr_en));

    p_self_off_after_word_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(en_q) && !$past(reg_wr)) |-> $past(wr_en));

    p_word_aligned_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr_lo == 2'b00));
endmodule

bind dma_chan_seq dma_chan_seq_chk u_chk (
    .clk(clk),
    .rst(rst),
    .bus_req(bus_req),
    .bus_gnt(bus_gnt),
    .pace_ok(pace_ok),
    .wr_en(wr_en),
    .rd_en(rd_en),
    .wr_addr_lo(wr_addr[1:0]),
    .irq(irq),
    .en_q(en_q),
    .reg_wr(reg_wr),
    .src_mode_bits(ctrl_q.src_mode)
);

// File: tb/sim_dma_chan_seq.sv
module sim_dma_chan_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam logic [31:0] RD_KEY = 32'hA5A5_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd5;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        trig = 1'b0;
    logic        pace_ok = 1'b1;
    logic        bus_req;
    logic        bus_gnt = 1'b1;
    logic        rd_en;
    logic [31:0] rd_addr;
    logic [31:0] rd_data;
    logic        wr_en;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int words  = 0;
    int irqs   = 0;
    logic throttle = 1'b0;
    logic [7:0] lf = 8'h5B;

    // behavioural reference state
    logic [31:0] m_src, m_dst, m_src_p, m_dst_p, m_fill, m_ctrl;
    int          m_per, m_total, m_left, m_tot;
    logic        m_en, m_busy, m_pend, m_irq;

    assign rd_data = rd_addr ^ RD_KEY;

    dma_chan_seq u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig(trig),
        .pace_ok(pace_ok), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] a, input logic [1:0] md);
        if (md == 2'd0) return a + 32'd4;
        if (md == 2'd1) return a - 32'd4;
        return a;
    endfunction

    // grant and pacing driver
    always @(posedge clk) begin
        #1;
        if (throttle) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            bus_gnt = lf[0] | lf[3];
            pace_ok = lf[1] | lf[2];
        end else begin
            bus_gnt = 1'b1;
            pace_ok = 1'b1;
        end
    end

    // reference model, updated from inputs that are stable at the edge
    always @(posedge clk) begin
        if (rst) begin
            m_src = '0; m_dst = '0; m_src_p = '0; m_dst_p = '0;
            m_fill = '0; m_ctrl = '0; m_per = 0; m_total = 0;
            m_left = 0; m_tot = 0; m_en = 0; m_busy = 0; m_pend = 0; m_irq = 0;
        end else begin
            bit imm, rep, os, mv, lst, fin, tacc, nb, np, ne;
            imm  = m_ctrl[28];
            rep  = m_ctrl[29];
            os   = !imm && !rep;
            mv   = m_busy && bus_gnt && pace_ok;
            lst  = mv && (m_left == 1 || (os && m_tot == 1));
            fin  = lst && (imm || (os && m_tot == 1));
            tacc = trig && m_en && !imm;
            m_irq = lst && (fin || rep) && m_ctrl[30];
            if (mv) begin
                m_src = step(m_src, m_ctrl[14:13]);
                m_dst = step(m_dst, m_ctrl[11:10]);
                if (m_left > 0) m_left--;
                if (m_tot > 0) m_tot--;
            end
            if (lst && m_ctrl[15]) m_src = m_src_p;
            if (lst && m_ctrl[12]) m_dst = m_dst_p;
            ne = m_en; nb = m_busy; np = m_pend;
            if (fin) begin
                ne = 0; nb = 0; np = 0;
            end else if (lst) begin
                nb = m_pend || tacc; np = 0;
                if (nb) m_left = m_per;
            end else if (tacc) begin
                if (m_busy) np = 1;
                else begin nb = 1; m_left = m_per; end
            end
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: begin m_src = reg_wdata & ~32'd3; m_src_p = m_src; end
                    3'd1: begin m_dst = reg_wdata & ~32'd3; m_dst_p = m_dst; end
                    3'd2: m_total = int'(reg_wdata[27:0]);
                    3'd3: m_per = int'(reg_wdata[23:0]);
                    3'd4: m_fill = reg_wdata;
                    3'd5: begin
                        if (!reg_wdata[31]) begin
                            ne = 0; nb = 0; np = 0;
                        end else if (!m_en) begin
                            ne = 1; np = 0; m_tot = m_total; nb = reg_wdata[28];
                            if (reg_wdata[28]) m_left = m_per;
                        end
                        m_ctrl = reg_wdata;
                    end
                    default: ;
                endcase
            end
            m_en = ne; m_busy = nb; m_pend = np;
        end
    end

    // cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            bit exp_wr;
            exp_wr = m_busy && bus_gnt && pace_ok;
            check(bus_req == m_busy, "R9 bus_req", 32'(bus_req), 32'(m_busy));
            check(wr_en == exp_wr, "R9 wr_en", 32'(wr_en), 32'(exp_wr));
            check(rd_en == (exp_wr && m_ctrl[14:13] != 2'd3), "R3 rd_en",
                  32'(rd_en), 32'(exp_wr && m_ctrl[14:13] != 2'd3));
            check(irq == m_irq, "R10 irq", 32'(irq), 32'(m_irq));
            if (exp_wr) begin
                check(wr_addr == m_dst, "R2/R4 wr_addr", wr_addr, m_dst);
                if (m_ctrl[14:13] == 2'd3)
                    check(wr_data == m_fill, "R3 fill data", wr_data, m_fill);
                else begin
                    check(rd_addr == m_src, "R3/R4 rd_addr", rd_addr, m_src);
                    check(wr_data == (m_src ^ RD_KEY), "R3 data", wr_data, m_src ^ RD_KEY);
                end
            end
            if (!reg_wr && reg_addr == 3'd5)
                check(reg_rdata[31] == m_en, "R5/R7 enable flag",
                      32'(reg_rdata[31]), 32'(m_en));
            if (wr_en) words++;
            if (irq) irqs++;
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 3'd5;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        @(posedge clk); #1;
        reg_addr = 3'd5;
    endtask

    task automatic pulse_trig();
        @(posedge clk); #1; trig = 1'b1;
        @(posedge clk); #1; trig = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!bus_req) break;
        end
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(bus_req == 0 && irq == 0 && reg_rdata == 0, "reset state R9",
              {reg_rdata[29:0], bus_req, irq}, 32'd0);

        // R1: address load with alignment
        wr_reg(3'd0, 32'h0000_1003);
        wr_reg(3'd1, 32'h0000_2002);
        rd_reg(3'd0, rd);
        check(rd == 32'h1000, "R1 src readback", rd, 32'h1000);
        rd_reg(3'd1, rd);
        check(rd == 32'h2000, "R1 dst readback", rd, 32'h2000);

        // R5: immediate, src inc, dst dec, repeat bit set but ignored, throttled
        throttle = 1'b1;
        words = 0; irqs = 0;
        wr_reg(3'd3, 32'd3);
        wr_reg(3'd2, 32'd1);
        wr_reg(3'd5, 32'hF000_0400);
        wait_idle();
        check(words == 3, "R5 immediate word count", words, 3);
        check(irqs == 1, "R10 immediate irq", irqs, 1);
        rd_reg(3'd5, rd);
        check(rd[31] == 1'b0, "R5 enable cleared", 32'(rd[31]), 0);
        rd_reg(3'd1, rd);
        check(rd == 32'h2000 - 32'd12, "R2 dst decremented", rd, 32'h2000 - 32'd12);

        // R6/R8: repeat, src dec, dst fixed, extra triggers merged
        throttle = 1'b0;
        words = 0; irqs = 0;
        wr_reg(3'd0, 32'h0000_3000);
        wr_reg(3'd1, 32'h0000_4000);
        wr_reg(3'd3, 32'd4);
        wr_reg(3'd5, 32'hE000_2800);
        pulse_trig();
        pulse_trig();
        pulse_trig();
        wait_idle();
        check(words == 8, "R8 pending merged", words, 8);
        check(irqs == 2, "R10 repeat irq per batch", irqs, 2);
        pulse_trig();
        wait_idle();
        check(words == 12, "R6 repeat trigger", words, 12);
        rd_reg(3'd5, rd);
        check(rd[31] == 1'b1, "R6 stays enabled", 32'(rd[31]), 1);
        rd_reg(3'd0, rd);
        check(rd == 32'h3000 - 32'd48, "R3 src decremented", rd, 32'h3000 - 32'd48);

        // R11: stop mid batch
        words = 0;
        wr_reg(3'd3, 32'd40);
        pulse_trig();
        repeat (4) @(posedge clk);
        wr_reg(3'd5, 32'h0000_0000);
        @(negedge clk);
        check(bus_req == 0, "R11 stopped", 32'(bus_req), 0);
        check(words < 40, "R11 batch cut", words, 40);
        pulse_trig();
        @(negedge clk);
        check(bus_req == 0, "R11 trigger ignored when off", 32'(bus_req), 0);

        // R7/R4: one-shot fill, total 5 in batches of 2, dst reload
        throttle = 1'b1;
        words = 0; irqs = 0;
        wr_reg(3'd0, 32'h0000_5000);
        wr_reg(3'd1, 32'h0000_6000);
        wr_reg(3'd4, 32'hCAFE_F00D);
        wr_reg(3'd3, 32'd2);
        wr_reg(3'd2, 32'd5);
        wr_reg(3'd5, 32'hC000_7000);
        for (int k = 0; k < 3; k++) begin
            pulse_trig();
            wait_idle();
            rd_reg(3'd1, rd);
            check(rd == 32'h6000, "R4 dst reloaded", rd, 32'h6000);
        end
        check(words == 5, "R7 total words", words, 5);
        check(irqs == 1, "R10 one-shot single irq", irqs, 1);
        rd_reg(3'd5, rd);
        check(rd[31] == 1'b0, "R7 enable cleared", 32'(rd[31]), 0);
        rd_reg(3'd0, rd);
        check(rd == 32'h5000, "R3 fill leaves src", rd, 32'h5000);

        throttle = 1'b0;
        repeat (5) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule